// File: doc/BRIEF.md
# Write-Allocate Store Miss Controller

This block sits between a processor store port and a write-back first-level data cache with 32-byte lines. For every store, the cache supplies a hit/miss result. Hits are accepted at once and cause no memory traffic. On a miss, the block decides whether to allocate the line. To allocate, it fetches the whole line with a four-beat burst read, merges the store bytes into the fetched data, and hands the merged line to the cache together with its final coherence state. A store that is not allocated leaves as a single write to memory.

Allocation depends on a small control register. A 7-bit limit field, in units of 4 MB, bounds the allocatable address range; a value of zero turns allocation off. A hole bit excludes the 15–16 MB window. A ninth bit is a plain flag that software can read and write without affecting anything else. The final coherence state depends on the write-back indication and the page write-through attribute seen on the last beat of the burst. A line that ends in Shared also sends the store through to memory. The store port is stalled while a miss is being handled, so at most one miss is in flight.

Top module: `wa_miss_ctrl`

## Requirements
- R1: After reset, `st_ready` is 1, `mem_req` and `fill_valid` are 0, and `cfg_rdata` reads 0, so allocation is disabled.
- R2: A store accepted with `st_hit`=1 completes in its acceptance cycle and produces no memory request and no line fill.
- R3: An allocating miss raises `mem_req` with `mem_burst`=1, `mem_we`=0 and `mem_addr` equal to the store address with its low 5 bits cleared. The request holds its address until `mem_ack`.
- R4: After four `mem_rvalid` beats, which fill 64-bit words 0 to 3 of the line in order, `fill_valid` pulses for one cycle. `fill_addr` is the line base. Word w of `fill_line` sits in bits [64w+63:64w]. In the word selected by store address bits 4:3, every byte b with `st_be[b]`=1 takes store data byte b. Every other byte equals the fetched beat.
- R5: `fill_state` uses the codes Invalid=00, Shared=01, Exclusive=10 and Modified=11. It is Modified when `attr_wb`=1 and `attr_pwt`=0 on the last beat, and the miss then ends with no further request. Otherwise it is Shared, and exactly one write request follows. That request has `mem_burst`=0, `mem_we`=1, `mem_addr` equal to the store address, and the store data and byte enables.
- R6: The limit field is `cfg_rdata[7:1]` (L). A cacheable miss is allocated only if L≠0 and the address is below L×4 MB. Any other cacheable miss becomes a single write (as in R5) with no burst and no fill.
- R7: When `cfg_rdata[0]`=1, a miss with address in [0x00F0_0000, 0x0100_0000) is not allocated and becomes a single write. Addresses just outside the window still allocate.
- R8: A write of `cfg_wdata` with `cfg_we`=1 reads back unchanged on `cfg_rdata` in the next cycle. Bit 8 has no effect on allocation.
- R9: A miss with `st_cacheable`=0 becomes a single write, whatever the register holds.
- R10: `st_ready` is 0 from the cycle after a miss is accepted until the miss completes. Store-port inputs changed during that time do not alter the request or fill contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 9 | Control register write value |
| cfg_rdata | output | 9 | Control register contents |
| st_valid | input | 1 | Store presented |
| st_ready | output | 1 | Store port can accept |
| st_addr | input | 32 | Store byte address |
| st_data | input | 64 | Store data, aligned to its 64-bit word |
| st_be | input | 8 | Store byte enables |
| st_hit | input | 1 | Cache lookup hit for this store |
| st_cacheable | input | 1 | Store address is cacheable |
| attr_wb | input | 1 | Write-back indication from the memory side |
| attr_pwt | input | 1 | Page write-through attribute |
| mem_req | output | 1 | Memory request |
| mem_burst | output | 1 | Request is a line burst read |
| mem_we | output | 1 | Request is a single write |
| mem_addr | output | 32 | Request address |
| mem_wdata | output | 64 | Write data |
| mem_be | output | 8 | Write byte enables |
| mem_ack | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Burst read beat valid |
| mem_rdata | input | 64 | Burst read beat data |
| fill_valid | output | 1 | Merged line ready for the cache |
| fill_addr | output | 32 | Line base address of the fill |
| fill_line | output | 256 | Merged line data |
| fill_state | output | 2 | Final coherence state of the line |

## Verification
The assertions assume well-behaved memory-side inputs. `mem_ack` is raised only while `mem_req` is high. `mem_rvalid` arrives only after a burst request is acknowledged, and exactly four times. The attribute inputs are steady while a miss is outstanding. The bench's memory responder acknowledges only a visible request, sometimes after a delay of a few cycles. It starts the four beats on the cycle after the acknowledge and never raises `mem_rvalid` otherwise. The store driver holds `attr_wb` and `attr_pwt` constant from acceptance until the port is ready again.

// File: rtl/wa_pkg.sv
package wa_pkg;

    localparam int CFG_W = 9;

    // Control register layout: flag bit 8, limit in 4 MB units at 7:1, hole enable at 0
    typedef struct packed {
        logic       flag;
        logic [6:0] limit4m;
        logic       hole_en;
    } wa_cfg_t;

    typedef enum logic [1:0] {
        MESI_I = 2'b00,
        MESI_S = 2'b01,
        MESI_E = 2'b10,
        MESI_M = 2'b11
    } mesi_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RREQ,
        ST_RDATA,
        ST_FILL,
        ST_WREQ
    } ctl_state_e;

    localparam int UNIT_SH = 22;  // 4 MB granule
    localparam int MB_SH   = 20;  // 1 MB granule
    localparam int HOLE_MB = 15;

    function automatic mesi_e final_state(input logic wb, input logic pwt);
        return (wb && !pwt) ? MESI_M : MESI_S;
    endfunction

endpackage

// File: rtl/wa_alloc_decide.sv
module wa_alloc_decide
    import wa_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-MB_SH-1:0] addr_mb,
    input  logic                    cacheable,
    input  logic [6:0]              limit4m,
    input  logic                    hole_en,
    output logic                    alloc
);
    localparam int UNIT_W = ADDR_W - UNIT_SH;
    localparam int MB_W   = ADDR_W - MB_SH;

    logic [UNIT_W-1:0] addr_unit;
    logic              below_limit;
    logic              in_hole;

    assign addr_unit   = addr_mb[MB_W-1:UNIT_SH-MB_SH];
    assign below_limit = addr_unit < UNIT_W'(limit4m);
    assign in_hole     = hole_en && (addr_mb == MB_W'(HOLE_MB));
    assign alloc       = cacheable && (limit4m != '0) && below_limit && !in_hole;

endmodule

// File: rtl/wa_line_buf.sv
module wa_line_buf #(
    parameter int BEAT_W = 64,
    parameter int BEATS  = 4
) (
    input  logic                      clk,
    input  logic                      beat_we,
    input  logic [$clog2(BEATS)-1:0]  beat_idx,
    input  logic [BEAT_W-1:0]         beat_data,
    input  logic [$clog2(BEATS)-1:0]  st_word,
    input  logic [BEAT_W-1:0]         st_data,
    input  logic [BEAT_W/8-1:0]       st_be,
    output logic [BEATS*BEAT_W-1:0]   line
);
    localparam int BE_W = BEAT_W / 8;

    logic [BEATS-1:0][BEAT_W-1:0] buf_q;
    logic [BEAT_W-1:0]            merged;
    logic                         hit_word;

    assign hit_word = (beat_idx == st_word);

    for (genvar b = 0; b < BE_W; b++) begin : g_byte
        assign merged[b*8 +: 8] = (hit_word && st_be[b]) ? st_data[b*8 +: 8]
                                                         : beat_data[b*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (beat_we) begin
            buf_q[beat_idx] <= merged;
        end
    end

    assign line = buf_q;

endmodule

// File: rtl/wa_ctl_fsm.sv
module wa_ctl_fsm
    import wa_pkg::*;
#(
    parameter int BEATS = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      start_alloc,
    input  logic                      mem_ack,
    input  logic                      mem_rvalid,
    input  logic                      attr_wb,
    input  logic                      attr_pwt,
    output logic                      idle,
    output logic                      rd_req,
    output logic                      wr_req,
    output logic                      beat_we,
    output logic [$clog2(BEATS)-1:0]  beat_idx,
    output logic                      fill_valid,
    output mesi_e                     fill_state
);
    localparam int IDX_W = $clog2(BEATS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(BEATS - 1);

    ctl_state_e           state_q;
    logic [IDX_W-1:0]     cnt_q;
    mesi_e                mesi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            mesi_q  <= MESI_I;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= start_alloc ? ST_RREQ : ST_WREQ;
                    end
                end
                ST_RREQ: begin
                    if (mem_ack) begin
                        state_q <= ST_RDATA;
                        cnt_q   <= '0;
                    end
                end
                ST_RDATA: begin
                    if (mem_rvalid) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == LAST) begin
                            state_q <= ST_FILL;
                            mesi_q  <= final_state(attr_wb, attr_pwt);
                        end
                    end
                end
                ST_FILL: begin
                    state_q <= (mesi_q == MESI_M) ? ST_IDLE : ST_WREQ;
                end
                ST_WREQ: begin
                    if (mem_ack) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign idle       = (state_q == ST_IDLE);
    assign rd_req     = (state_q == ST_RREQ);
    assign wr_req     = (state_q == ST_WREQ);
    assign beat_we    = (state_q == ST_RDATA) && mem_rvalid;
    assign beat_idx   = cnt_q;
    assign fill_valid = (state_q == ST_FILL);
    assign fill_state = mesi_q;

endmodule

// File: rtl/wa_miss_ctrl.sv
module wa_miss_ctrl
    import wa_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BEAT_W     = 64,
    parameter int LINE_BYTES = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic [CFG_W-1:0]             cfg_wdata,
    output logic [CFG_W-1:0]             cfg_rdata,
    input  logic                         st_valid,
    output logic                         st_ready,
    input  logic [ADDR_W-1:0]            st_addr,
    input  logic [BEAT_W-1:0]            st_data,
    input  logic [BEAT_W/8-1:0]          st_be,
    input  logic                         st_hit,
    input  logic                         st_cacheable,
    input  logic                         attr_wb,
    input  logic                         attr_pwt,
    output logic                         mem_req,
    output logic                         mem_burst,
    output logic                         mem_we,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic [BEAT_W-1:0]            mem_wdata,
    output logic [BEAT_W/8-1:0]          mem_be,
    input  logic                         mem_ack,
    input  logic                         mem_rvalid,
    input  logic [BEAT_W-1:0]            mem_rdata,
    output logic                         fill_valid,
    output logic [ADDR_W-1:0]            fill_addr,
    output logic [LINE_BYTES*8-1:0]      fill_line,
    output logic [1:0]                   fill_state
);
    localparam int BE_W   = BEAT_W / 8;
    localparam int BEATS  = LINE_BYTES / BE_W;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int BOFF_W = $clog2(BE_W);
    localparam int IDX_W  = $clog2(BEATS);

    wa_cfg_t             cfg_q;
    logic [ADDR_W-1:0]   pend_addr;
    logic [BEAT_W-1:0]   pend_data;
    logic [BE_W-1:0]     pend_be;
    logic                alloc_now;
    logic                start;
    logic                rd_req;
    logic                wr_req;
    logic                beat_we;
    logic [IDX_W-1:0]    beat_idx;
    mesi_e               fsm_state;
    logic [ADDR_W-1:0]   line_base;

    // control register
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= wa_cfg_t'(cfg_wdata);
        end
    end
    assign cfg_rdata = cfg_q;

    assign start = st_valid && st_ready && !st_hit;

    wa_alloc_decide #(.ADDR_W(ADDR_W)) u_decide (
        .addr_mb   (st_addr[ADDR_W-1:MB_SH]),
        .cacheable (st_cacheable),
        .limit4m   (cfg_q.limit4m),
        .hole_en   (cfg_q.hole_en),
        .alloc     (alloc_now)
    );

    // pending store capture
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_addr <= '0;
            pend_data <= '0;
            pend_be   <= '0;
        end else if (start) begin
            pend_addr <= st_addr;
            pend_data <= st_data;
            pend_be   <= st_be;
        end
    end

    wa_ctl_fsm #(.BEATS(BEATS)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_alloc (alloc_now),
        .mem_ack     (mem_ack),
        .mem_rvalid  (mem_rvalid),
        .attr_wb     (attr_wb),
        .attr_pwt    (attr_pwt),
        .idle        (st_ready),
        .rd_req      (rd_req),
        .wr_req      (wr_req),
        .beat_we     (beat_we),
        .beat_idx    (beat_idx),
        .fill_valid  (fill_valid),
        .fill_state  (fsm_state)
    );

    wa_line_buf #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_line (
        .clk       (clk),
        .beat_we   (beat_we),
        .beat_idx  (beat_idx),
        .beat_data (mem_rdata),
        .st_word   (pend_addr[OFF_W-1:BOFF_W]),
        .st_data   (pend_data),
        .st_be     (pend_be),
        .line      (fill_line)
    );

    assign line_base  = {pend_addr[ADDR_W-1:OFF_W], OFF_W'(0)};
    assign mem_req    = rd_req || wr_req;
    assign mem_burst  = rd_req;
    assign mem_we     = wr_req;
    assign mem_addr   = rd_req ? line_base : pend_addr;
    assign mem_wdata  = pend_data;
    assign mem_be     = wr_req ? pend_be : '0;
    assign fill_addr  = line_base;
    assign fill_state = fsm_state;

endmodule

// File: rtl/wa_miss_ctrl_chk.sv
module wa_miss_ctrl_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    parameter int CFG_W  = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              st_ready,
    input logic              mem_req,
    input logic              mem_burst,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              fill_valid,
    input logic [OFF_W-1:0]  fill_off,
    input logic [1:0]        fill_state,
    input logic              cfg_we,
    input logic [CFG_W-1:0]  cfg_wdata,
    input logic [CFG_W-1:0]  cfg_rdata
);
    p_burst_read_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_burst |-> !mem_we && (mem_addr[OFF_W-1:0] == '0));

    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_burst));

    p_fill_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> !fill_valid);

    p_fill_align_r4: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> fill_off == '0);

    p_fill_state_r5: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> (fill_state == 2'b11) || (fill_state == 2'b01));

    p_modified_done_r5: assert property (@(posedge clk) disable iff (rst)
        fill_valid && fill_state == 2'b11 |=> st_ready && !mem_req);

    p_single_write_r6: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_burst |-> mem_we);

    p_cfg_readback_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> cfg_rdata == $past(cfg_wdata));

    p_stall_r10: assert property (@(posedge clk) disable iff (rst)
        mem_req || fill_valid |-> !st_ready);

endmodule

bind wa_miss_ctrl wa_miss_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .CFG_W  (wa_pkg::CFG_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .st_ready   (st_ready),
    .mem_req    (mem_req),
    .mem_burst  (mem_burst),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .fill_valid (fill_valid),
    .fill_off   (fill_addr[OFF_W-1:0]),
    .fill_state (fill_state),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata)
);

// File: tb/wa_miss_ctrl_test.sv
module wa_miss_ctrl_test;
    localparam int BEATS = 4;

    logic         clk;
    logic         rst;
    logic         cfg_we;
    logic [8:0]   cfg_wdata;
    logic [8:0]   cfg_rdata;
    logic         st_valid;
    logic         st_ready;
    logic [31:0]  st_addr;
    logic [63:0]  st_data;
    logic [7:0]   st_be;
    logic         st_hit;
    logic         st_cacheable;
    logic         attr_wb;
    logic         attr_pwt;
    logic         mem_req;
    logic         mem_burst;
    logic         mem_we;
    logic [31:0]  mem_addr;
    logic [63:0]  mem_wdata;
    logic [7:0]   mem_be;
    logic         mem_ack;
    logic         mem_rvalid;
    logic [63:0]  mem_rdata;
    logic         fill_valid;
    logic [31:0]  fill_addr;
    logic [255:0] fill_line;
    logic [1:0]   fill_state;

    wa_miss_ctrl uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
        .st_be(st_be), .st_hit(st_hit), .st_cacheable(st_cacheable),
        .attr_wb(attr_wb), .attr_pwt(attr_pwt),
        .mem_req(mem_req), .mem_burst(mem_burst), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_line(fill_line),
        .fill_state(fill_state)
    );

    typedef struct {
        int           kind;   // 0 burst read, 1 single write, 2 fill
        logic [31:0]  addr;
        logic [63:0]  data;
        logic [7:0]   be;
        logic [255:0] line;
        logic [1:0]   st;
        string        req;
    } ev_t;

    ev_t        q[$];
    int         checks = 0;
    int         errors = 0;
    bit         done = 0;
    int         ack_delay = 0;
    logic [8:0] cfg_model = '0;

    initial begin
        clk = 0;
        forever #4 clk = ~clk;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] beat_val(input logic [31:0] base, input int k);
        return {base + 32'(k * 8), 32'hC0DE_0000 | 32'(k)};
    endfunction

    function automatic bit bench_alloc(input logic [31:0] a, input bit cach);
        logic [63:0] limit;
        bit          hole;
        limit = 64'(cfg_model[7:1]) << 22;
        hole  = cfg_model[0] && (a >= 32'h00F0_0000) && (a < 32'h0100_0000);
        return cach && (cfg_model[7:1] != 0) && (64'(a) < limit) && !hole;
    endfunction

    task automatic take_event(input int kind, input logic [31:0] addr, input logic [63:0] data,
                              input logic [7:0] be, input logic [255:0] line, input logic [1:0] st);
        ev_t e;
        if (q.size() == 0) begin
            chk(0, "R2", "unexpected memory or fill event, kind", 256'(kind), 256'(99));
            return;
        end
        e = q.pop_front();
        chk(e.kind == kind, e.req, "event kind", 256'(kind), 256'(e.kind));
        if (e.kind != kind) return;
        chk(addr == e.addr, e.req, "address", 256'(addr), 256'(e.addr));
        if (kind == 1) begin
            chk(data == e.data, e.req, "write data", 256'(data), 256'(e.data));
            chk(be == e.be, e.req, "write byte enables", 256'(be), 256'(e.be));
        end
        if (kind == 2) begin
            chk(line == e.line, "R4", "merged line", line, e.line);
            chk(st == e.st, "R5", "fill state", 256'(st), 256'(e.st));
        end
    endtask

    // memory responder and fill monitor
    initial begin
        int          wait_cnt;
        int          beats_left;
        logic [31:0] rd_base;
        wait_cnt   = 0;
        beats_left = 0;
        rd_base    = '0;
        mem_ack    = 0;
        mem_rvalid = 0;
        mem_rdata  = '0;
        forever begin
            @(negedge clk);
            mem_ack = 0;
            if (beats_left > 0) begin
                mem_rvalid = 1;
                mem_rdata  = beat_val(rd_base, BEATS - beats_left);
                beats_left--;
            end else begin
                mem_rvalid = 0;
            end
            if (!rst && fill_valid) begin
                take_event(2, fill_addr, '0, '0, fill_line, fill_state);
            end
            if (!rst && mem_req) begin
                if (wait_cnt < ack_delay) begin
                    wait_cnt++;
                end else begin
                    wait_cnt = 0;
                    mem_ack  = 1;
                    chk(mem_we == !mem_burst, "R3", "request direction", 256'(mem_we), 256'(!mem_burst));
                    take_event(mem_burst ? 0 : 1, mem_addr, mem_wdata, mem_be, '0, 2'b00);
                    if (mem_burst) begin
                        beats_left = BEATS;
                        rd_base    = mem_addr;
                    end
                end
            end
        end
    end

    task automatic cfg_write(input logic [8:0] v);
        @(negedge clk);
        cfg_we    = 1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 0;
        cfg_wdata = '0;
        cfg_model = v;
        chk(cfg_rdata == v, "R8", "control register readback", 256'(cfg_rdata), 256'(v));
    endtask

    task automatic store(input logic [31:0] a, input logic [63:0] d, input logic [7:0] be,
                         input bit hit, input bit cach, input bit wb, input bit pwt,
                         input string req);
        ev_t          e;
        logic [255:0] line;
        logic [63:0]  w;
        logic [1:0]   st;
        if (!hit) begin
            if (bench_alloc(a, cach)) begin
                e = '{0, {a[31:5], 5'b0}, '0, '0, '0, 2'b00, req};
                q.push_back(e);
                for (int k = 0; k < BEATS; k++) begin
                    w = beat_val({a[31:5], 5'b0}, k);
                    if (k == int'(a[4:3])) begin
                        for (int b = 0; b < 8; b++) begin
                            if (be[b]) w[b*8 +: 8] = d[b*8 +: 8];
                        end
                    end
                    line[k*64 +: 64] = w;
                end
                st = (wb && !pwt) ? 2'b11 : 2'b01;
                e = '{2, {a[31:5], 5'b0}, '0, '0, line, st, req};
                q.push_back(e);
                if (st == 2'b01) begin
                    e = '{1, a, d, be, '0, 2'b00, "R5"};
                    q.push_back(e);
                end
            end else begin
                e = '{1, a, d, be, '0, 2'b00, req};
                q.push_back(e);
            end
        end
        @(negedge clk);
        st_addr      = a;
        st_data      = d;
        st_be        = be;
        st_hit       = hit;
        st_cacheable = cach;
        attr_wb      = wb;
        attr_pwt     = pwt;
        st_valid     = 1;
        @(negedge clk);
        st_valid     = 0;
        st_addr      = 32'hDEAD_BEE8;  // R10: changes while stalled must not leak in
        st_data      = '1;
        st_be        = 8'hFF;
        if (!hit) begin
            chk(!st_ready, "R10", "ready while miss in flight", 256'(st_ready), 256'(0));
        end
        for (int i = 0; i < 300 && !(st_ready && q.size() == 0); i++) begin
            @(negedge clk);
        end
        if (hit) begin
            repeat (3) @(negedge clk);
            chk(st_ready, "R2", "ready after hit", 256'(st_ready), 256'(1));
        end
        chk(q.size() == 0, req, "outstanding expected events", 256'(q.size()), 256'(0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; cfg_we = 0; cfg_wdata = '0; st_valid = 0; st_addr = '0; st_data = '0;
        st_be = '0; st_hit = 0; st_cacheable = 0; attr_wb = 0; attr_pwt = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(st_ready == 1, "R1", "reset ready", 256'(st_ready), 256'(1));
        chk(mem_req == 0, "R1", "reset mem_req", 256'(mem_req), 256'(0));
        chk(fill_valid == 0, "R1", "reset fill_valid", 256'(fill_valid), 256'(0));
        chk(cfg_rdata == 0, "R1", "reset register", 256'(cfg_rdata), 256'(0));

        // R1: reset value disables allocation
        store(32'h0000_1008, 64'h1111_2222_3333_4444, 8'hFF, 0, 1, 1, 0, "R1");

        cfg_write(9'h021);  // limit 64 MB, hole on
        store(32'h0000_1000, 64'h0123_4567_89AB_CDEF, 8'hFF, 1, 1, 1, 0, "R2");

        ack_delay = 2;
        store(32'h0012_3458, 64'hAAAA_BBBB_CCCC_DDDD, 8'h0F, 0, 1, 1, 0, "R3");
        ack_delay = 0;
        store(32'h0012_3460, 64'h5555_6666_7777_8888, 8'hFF, 0, 1, 1, 1, "R5");
        store(32'h0000_0018, 64'h9999_0000_1234_5678, 8'h81, 0, 1, 0, 0, "R4");
        store(32'h0400_0000, 64'hFEED_FACE_0000_0001, 8'h3C, 0, 1, 1, 0, "R6");
        store(32'h03FF_FFF8, 64'hFEED_FACE_0000_0002, 8'hF0, 0, 1, 1, 0, "R6");
        store(32'h00F0_0010, 64'h0BAD_F00D_0000_0003, 8'h0F, 0, 1, 1, 0, "R7");
        store(32'h00EF_FFF0, 64'h0BAD_F00D_0000_0004, 8'hFF, 0, 1, 1, 0, "R7");
        store(32'h0100_0000, 64'h0BAD_F00D_0000_0005, 8'h01, 0, 1, 1, 0, "R7");
        store(32'h0000_2000, 64'hC0FF_EE00_0000_0006, 8'hFF, 0, 0, 1, 0, "R9");

        cfg_write(9'h120);  // flag set, limit 64 MB, hole off
        store(32'h00F0_0010, 64'h0BAD_F00D_0000_0007, 8'h0F, 0, 1, 1, 0, "R8");
        store(32'h0400_0008, 64'h0BAD_F00D_0000_0008, 8'hFF, 0, 1, 1, 0, "R8");

        cfg_write(9'h100);  // limit zero: allocation off
        store(32'h0000_0040, 64'h7777_0000_0000_0009, 8'hFF, 0, 1, 1, 0, "R6");

        repeat (4) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule